// File: doc/BRIEF.md
# Synthesizer Divider Chain and Phase-Frequency Detector

This block is the digital core of a frequency synthesizer loop. The oscillator signal first passes a fixed divide-by-8 stage and then a programmable main divider. The reference signal passes a reference divider. A three-state phase-frequency detector compares the two divided pulse trains and produces pump-up and pump-down pulses. An external charge pump, loop filter and oscillator turn those pulses into a tuning voltage. When the loop settles, the oscillator runs at 8 × main ratio × reference frequency ÷ reference ratio.

All logic runs on one system clock. The oscillator input and the reference input are sampled as levels, and each rising edge counts as one input event. A mode flag selects one of two control formats. In two-wire mode the main ratio has 15 bits and the reference ratio is selectable. In three-wire mode the main ratio has 14 bits, the reference ratio is fixed and the high pump current is always used. Control bits can silence the pump, disable the whole loop output so that the tuning voltage can be set externally, and bring the divided pulse trains out for test. A lock flag reports when the detector pulses have stayed narrow for a run of comparison periods.

Top module: `synth_div_pfd`

## Requirements
- R1: While `rst` is high and on the cycle after it, `pump_up`, `pump_dn`, `cp_hi_sel`, `drive_en`, `locked`, `tst_div` and `tst_ref` are all 0.
- R2: The main divided pulse train has one pulse per 8 × `ratio` oscillator rising edges, and `tst_div` shows it when `test_en` is 1. With `two_wire`=1, `ref_sel`=2'b00, `ratio`=32 and oscillator and reference edges at the same rate and phase, the loop reports lock.
- R3: In two-wire mode (`two_wire`=1) the reference ratio is 256 for `ref_sel`=2'b00, 512 for 2'b01, and 1024 for both 2'b10 and 2'b11. `tst_ref` pulses once per that many reference rising edges.
- R4: In three-wire mode (`two_wire`=0) the reference ratio is 512 whatever `ref_sel` holds, and bit 14 of `ratio` is ignored.
- R5: A reference pulse sets the up state and a main-divider pulse sets the down state. When both are set, both clear after `RST_DLY` cycles, so `pump_up` and `pump_dn` are never high together for more than `RST_DLY` consecutive cycles. A slow oscillator gives mostly up time and a fast oscillator gives mostly down time.
- R6: When `pump_off` is 1, `pump_up` and `pump_dn` are 0 on the following cycle.
- R7: When `loop_off` is 1, `pump_up`, `pump_dn` and `drive_en` are 0 on the following cycle. Otherwise `drive_en` is 1.
- R8: When `test_en` is 0, `tst_div` and `tst_ref` are 0 on the following cycle.
- R9: `cp_hi_sel` follows `cp_hi` one cycle later in two-wire mode and is 1 in three-wire mode.
- R10: `locked` rises after 16 consecutive comparison periods in which neither internal pulse reached `LOCK_THRESH` cycles. It falls at the end of the first period in which one of them did.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| vco_in | input | 1 | Oscillator signal, sampled as a level |
| ref_in | input | 1 | Reference signal, sampled as a level |
| ratio | input | 15 | Main divider ratio |
| ref_sel | input | 2 | Reference ratio select (two-wire mode) |
| two_wire | input | 1 | 1 = two-wire format, 0 = three-wire format |
| cp_hi | input | 1 | Requested high pump current (two-wire mode) |
| pump_off | input | 1 | Suppress pump pulses |
| loop_off | input | 1 | Disable the whole loop output |
| test_en | input | 1 | Show divided pulse trains on the test outputs |
| pump_up | output | 1 | Pump-up pulse |
| pump_dn | output | 1 | Pump-down pulse |
| cp_hi_sel | output | 1 | Pump current select, 1 = high |
| drive_en | output | 1 | Pump drive amplifier enable |
| locked | output | 1 | Lock indicator |
| tst_div | output | 1 | Main divider pulses, for test |
| tst_ref | output | 1 | Reference divider pulses, for test |

## Verification
The bench measures the spacing of the test pulses for every reference select code, including both codes that map to 1024. A decoder that treated 2'b11 as its own case, or that failed to force 512 in three-wire mode, would show the wrong period. In three-wire mode it sets ratio bit 14 and expects the 14-bit period, which catches an unmasked bit. It detunes the oscillator both ways and compares the total up time with the total down time, so swapped detector inputs show up. It also pulls a locked loop off frequency and expects `locked` to fall within a few comparison periods, which catches a lock flag that sticks or counts in the wrong place.

// File: rtl/synth_pkg.sv
package synth_pkg;
  localparam int RATIO_W   = 15;
  localparam int REF_W     = 11;
  localparam int PRESCALE  = 8;

  // Reference ratio decode; three-wire mode forces the middle ratio.
  function automatic logic [REF_W-1:0] ref_ratio(input logic two_wire,
                                                 input logic [1:0] sel);
    logic [REF_W-1:0] r;
    if (!two_wire)          r = REF_W'(512);
    else if (sel == 2'b00)  r = REF_W'(256);
    else if (sel == 2'b01)  r = REF_W'(512);
    else                    r = REF_W'(1024);
    return r;
  endfunction
endpackage

// File: rtl/synth_edge.sv
module synth_edge (
  input  logic clk,
  input  logic rst,
  input  logic din,
  output logic rise
);
  logic [2:0] sh;

  always_ff @(posedge clk) begin
    if (rst) sh <= '0;
    else     sh <= {sh[1:0], din};
  end

  assign rise = sh[1] & ~sh[2];
endmodule

// File: rtl/synth_tick_div.sv
module synth_tick_div #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         tick,
  input  logic [W-1:0] ratio,
  output logic         pulse
);
  logic [W-1:0] cnt;
  logic [W-1:0] lim;

  // A ratio of zero behaves as one; ">=" keeps a lowered ratio from wrapping.
  assign lim = (ratio == '0) ? '0 : ratio - W'(1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt   <= '0;
      pulse <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (tick) begin
        if (cnt >= lim) begin
          cnt   <= '0;
          pulse <= 1'b1;
        end else begin
          cnt <= cnt + W'(1);
        end
      end
    end
  end
endmodule

// File: rtl/synth_pfd.sv
module synth_pfd #(
  parameter int RST_DLY = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_p,
  input  logic div_p,
  output logic up,
  output logic dn
);
  localparam int DW = $clog2(RST_DLY + 1);
  logic [DW-1:0] dly;
  logic          clr;

  assign clr = up && dn && (dly == DW'(RST_DLY - 1));

  always_ff @(posedge clk) begin
    if (rst) begin
      up  <= 1'b0;
      dn  <= 1'b0;
      dly <= '0;
    end else if (clr) begin
      up  <= 1'b0;
      dn  <= 1'b0;
      dly <= '0;
    end else begin
      if (ref_p) up <= 1'b1;
      if (div_p) dn <= 1'b1;
      if (up && dn) dly <= dly + DW'(1);
    end
  end
endmodule

// File: rtl/synth_lock.sv
module synth_lock #(
  parameter int THRESH = 8,
  parameter int COUNT  = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic ref_p,
  input  logic up,
  input  logic dn,
  output logic locked
);
  localparam int WW = $clog2(THRESH + 1);
  localparam int CW = $clog2(COUNT + 1);

  logic [WW-1:0] wu, wd;
  logic [CW-1:0] run;
  logic          cyc_ok;

  assign cyc_ok = (wu < WW'(THRESH)) && (wd < WW'(THRESH));

  always_ff @(posedge clk) begin
    if (rst) begin
      wu     <= '0;
      wd     <= '0;
      run    <= '0;
      locked <= 1'b0;
    end else if (ref_p) begin
      wu <= up ? WW'(1) : '0;
      wd <= dn ? WW'(1) : '0;
      if (cyc_ok) begin
        if (run < CW'(COUNT)) run <= run + CW'(1);
        locked <= (run >= CW'(COUNT - 1));
      end else begin
        run    <= '0;
        locked <= 1'b0;
      end
    end else begin
      if (up && wu < WW'(THRESH)) wu <= wu + WW'(1);
      if (dn && wd < WW'(THRESH)) wd <= wd + WW'(1);
    end
  end
endmodule

// File: rtl/synth_div_pfd.sv
module synth_div_pfd #(
  parameter int RST_DLY     = 2,
  parameter int LOCK_THRESH = 8,
  parameter int LOCK_COUNT  = 16
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        vco_in,
  input  logic        ref_in,
  input  logic [14:0] ratio,
  input  logic [1:0]  ref_sel,
  input  logic        two_wire,
  input  logic        cp_hi,
  input  logic        pump_off,
  input  logic        loop_off,
  input  logic        test_en,
  output logic        pump_up,
  output logic        pump_dn,
  output logic        cp_hi_sel,
  output logic        drive_en,
  output logic        locked,
  output logic        tst_div,
  output logic        tst_ref
);
  import synth_pkg::*;

  localparam int PW = $clog2(PRESCALE) + 1;

  logic vco_t, ref_t, pre_p, div_p, ref_p, up_i, dn_i;
  logic [RATIO_W-1:0] ratio_eff;
  logic [REF_W-1:0]   rratio;

  // Three-wire format carries one bit fewer of main ratio.
  assign ratio_eff = two_wire ? ratio : {1'b0, ratio[RATIO_W-2:0]};
  assign rratio    = ref_ratio(two_wire, ref_sel);

  synth_edge u_vco_edge (.clk(clk), .rst(rst), .din(vco_in), .rise(vco_t));
  synth_edge u_ref_edge (.clk(clk), .rst(rst), .din(ref_in), .rise(ref_t));

  synth_tick_div #(.W(PW)) u_pre (
    .clk(clk), .rst(rst), .tick(vco_t), .ratio(PW'(PRESCALE)), .pulse(pre_p));

  synth_tick_div #(.W(RATIO_W)) u_main (
    .clk(clk), .rst(rst), .tick(pre_p), .ratio(ratio_eff), .pulse(div_p));

  synth_tick_div #(.W(REF_W)) u_refd (
    .clk(clk), .rst(rst), .tick(ref_t), .ratio(rratio), .pulse(ref_p));

  synth_pfd #(.RST_DLY(RST_DLY)) u_pfd (
    .clk(clk), .rst(rst), .ref_p(ref_p), .div_p(div_p), .up(up_i), .dn(dn_i));

  synth_lock #(.THRESH(LOCK_THRESH), .COUNT(LOCK_COUNT)) u_lock (
    .clk(clk), .rst(rst), .ref_p(ref_p), .up(up_i), .dn(dn_i), .locked(locked));

  always_ff @(posedge clk) begin
    if (rst) begin
      pump_up   <= 1'b0;
      pump_dn   <= 1'b0;
      cp_hi_sel <= 1'b0;
      drive_en  <= 1'b0;
      tst_div   <= 1'b0;
      tst_ref   <= 1'b0;
    end else begin
      pump_up   <= up_i & ~pump_off & ~loop_off;
      pump_dn   <= dn_i & ~pump_off & ~loop_off;
      cp_hi_sel <= two_wire ? cp_hi : 1'b1;
      drive_en  <= ~loop_off;
      tst_div   <= div_p & test_en;
      tst_ref   <= ref_p & test_en;
    end
  end
endmodule

// File: rtl/synth_div_pfd_checker.sv
module synth_div_pfd_checker #(
  parameter int RST_DLY = 2
) (
  input logic clk,
  input logic rst,
  input logic two_wire,
  input logic cp_hi,
  input logic pump_off,
  input logic loop_off,
  input logic test_en,
  input logic pump_up,
  input logic pump_dn,
  input logic cp_hi_sel,
  input logic drive_en,
  input logic tst_div,
  input logic tst_ref
);
  int ov_cnt;

  always_ff @(posedge clk) begin
    if (rst)                    ov_cnt <= 0;
    else if (pump_up && pump_dn) ov_cnt <= ov_cnt + 1;
    else                        ov_cnt <= 0;
  end

  assert_overlap_bounded_R5: assert property (@(posedge clk) disable iff (rst)
    (pump_up && pump_dn) |-> (ov_cnt < RST_DLY));

  assert_pump_silenced_R6: assert property (@(posedge clk) disable iff (rst)
    pump_off |=> (!pump_up && !pump_dn));

  assert_loop_disabled_R7: assert property (@(posedge clk) disable iff (rst)
    loop_off |=> (!pump_up && !pump_dn && !drive_en));

  assert_test_hidden_R8: assert property (@(posedge clk) disable iff (rst)
    !test_en |=> (!tst_div && !tst_ref));

  assert_cur_three_wire_R9: assert property (@(posedge clk) disable iff (rst)
    !two_wire |=> cp_hi_sel);

  assert_cur_two_wire_R9: assert property (@(posedge clk) disable iff (rst)
    two_wire |=> (cp_hi_sel == $past(cp_hi)));
endmodule

bind synth_div_pfd synth_div_pfd_checker #(.RST_DLY(RST_DLY)) u_chk (
  .clk(clk), .rst(rst), .two_wire(two_wire), .cp_hi(cp_hi),
  .pump_off(pump_off), .loop_off(loop_off), .test_en(test_en),
  .pump_up(pump_up), .pump_dn(pump_dn), .cp_hi_sel(cp_hi_sel),
  .drive_en(drive_en), .tst_div(tst_div), .tst_ref(tst_ref));

// File: tb/synth_div_pfd_test.sv
module synth_div_pfd_test;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic vco_in = 1'b0, ref_in = 1'b0;
  logic [14:0] ratio = 15'd32;
  logic [1:0]  ref_sel = 2'b00;
  logic two_wire = 1'b1, cp_hi = 1'b0, pump_off = 1'b0, loop_off = 1'b0, test_en = 1'b1;
  logic pump_up, pump_dn, cp_hi_sel, drive_en, locked, tst_div, tst_ref;

  int errors = 0;
  int checks = 0;
  int cyc = 0;
  bit done = 0;

  always #4 clk = ~clk;

  // Oscillator and reference models: both toggle every cycle, in phase.
  always @(negedge clk) begin
    vco_in <= ~vco_in;
    ref_in <= ~ref_in;
    cyc    <= cyc + 1;
  end

  synth_div_pfd uut (
    .clk(clk), .rst(rst), .vco_in(vco_in), .ref_in(ref_in), .ratio(ratio),
    .ref_sel(ref_sel), .two_wire(two_wire), .cp_hi(cp_hi), .pump_off(pump_off),
    .loop_off(loop_off), .test_en(test_en), .pump_up(pump_up), .pump_dn(pump_dn),
    .cp_hi_sel(cp_hi_sel), .drive_en(drive_en), .locked(locked),
    .tst_div(tst_div), .tst_ref(tst_ref));

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic check_true(input string req, input bit cond, input int act, input int exp);
    checks++;
    if (!cond) begin
      errors++;
      $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic restart();
    @(negedge clk) rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
  endtask

  // Cycles between consecutive pulses on a test output (0 = tst_div, 1 = tst_ref).
  task automatic period(input bit which, output int per);
    int n;
    per = 0;
    for (int k = 0; k < 2; k++) begin
      n = 0;
      do begin @(negedge clk); n++; end while (!(which ? tst_ref : tst_div) && n < 6000);
      if (k == 1) per = n;
    end
  endtask

  task automatic t_reset();
    @(negedge clk) rst = 1'b1;
    repeat (2) @(negedge clk);
    check("R1 pump_up", pump_up, 0);
    check("R1 pump_dn", pump_dn, 0);
    check("R1 cp_hi_sel", cp_hi_sel, 0);
    check("R1 drive_en", drive_en, 0);
    check("R1 locked", locked, 0);
    check("R1 test outputs", tst_div | tst_ref, 0);
  endtask

  task automatic t_lock_two_wire();
    int p;
    two_wire = 1; ref_sel = 2'b00; ratio = 15'd32;
    restart();
    period(1'b0, p);
    check("R2 main divider period (8*32 edges)", p, 512);
    repeat (10000) @(negedge clk);
    check("R2 R10 lock acquired", locked, 1);
    check("R7 drive_en when loop on", drive_en, 1);
    ratio = 15'd40;
    repeat (2000) @(negedge clk);
    check("R10 lock lost after detune", locked, 0);
  endtask

  task automatic t_detune();
    int up_n, dn_n, ov, ov_max;
    two_wire = 1; ref_sel = 2'b00; ratio = 15'd40;
    restart();
    up_n = 0; dn_n = 0; ov = 0; ov_max = 0;
    repeat (4000) begin
      @(negedge clk);
      up_n += pump_up; dn_n += pump_dn;
      if (pump_up && pump_dn) ov++; else ov = 0;
      if (ov > ov_max) ov_max = ov;
    end
    check_true("R5 slow oscillator gives up time", up_n > dn_n, up_n, dn_n);
    ratio = 15'd24;
    restart();
    up_n = 0; dn_n = 0;
    repeat (4000) begin
      @(negedge clk);
      up_n += pump_up; dn_n += pump_dn;
      if (pump_up && pump_dn) ov++; else ov = 0;
      if (ov > ov_max) ov_max = ov;
    end
    check_true("R5 fast oscillator gives down time", dn_n > up_n, dn_n, up_n);
    check_true("R5 overlap within reset delay", ov_max <= 2, ov_max, 2);
  endtask

  task automatic t_ref_sel();
    int p;
    two_wire = 1; ratio = 15'd32;
    ref_sel = 2'b00; restart(); period(1'b1, p); check("R3 sel 00 -> 256", p, 512);
    ref_sel = 2'b01; restart(); period(1'b1, p); check("R3 sel 01 -> 512", p, 1024);
    ref_sel = 2'b10; restart(); period(1'b1, p); check("R3 sel 10 -> 1024", p, 2048);
    ref_sel = 2'b11; restart(); period(1'b1, p); check("R3 sel 11 -> 1024", p, 2048);
  endtask

  task automatic t_three_wire();
    int p;
    two_wire = 0; ref_sel = 2'b00; ratio = 15'h4040;  // bit 14 set, low bits 64
    restart();
    period(1'b1, p); check("R4 reference fixed at 512", p, 1024);
    period(1'b0, p); check("R4 bit 14 ignored", p, 1024);
    repeat (20000) @(negedge clk);
    check("R4 lock in three-wire mode", locked, 1);
    two_wire = 1;
  endtask

  task automatic t_pump_off();
    int n;
    two_wire = 1; ref_sel = 2'b00; ratio = 15'd40; pump_off = 1;
    restart();
    n = 0;
    repeat (3000) begin @(negedge clk); n += pump_up + pump_dn; end
    check("R6 no pulses with pump off", n, 0);
    pump_off = 0;
  endtask

  task automatic t_loop_off();
    int n;
    ratio = 15'd40; loop_off = 1;
    restart();
    n = 0;
    repeat (3000) begin @(negedge clk); n += pump_up + pump_dn; end
    check("R7 no pulses with loop off", n, 0);
    check("R7 drive_en low", drive_en, 0);
    loop_off = 0;
  endtask

  task automatic t_test_bit();
    int n;
    ratio = 15'd32; test_en = 0;
    restart();
    n = 0;
    repeat (3000) begin @(negedge clk); n += tst_div + tst_ref; end
    check("R8 test outputs hidden", n, 0);
    test_en = 1;
    n = 0;
    repeat (3000) begin @(negedge clk); n += tst_div + tst_ref; end
    check_true("R8 test outputs visible", n > 0, n, 1);
  endtask

  task automatic t_cur_sel();
    two_wire = 1; cp_hi = 0; repeat (2) @(negedge clk);
    check("R9 two-wire low current", cp_hi_sel, 0);
    cp_hi = 1; repeat (2) @(negedge clk);
    check("R9 two-wire high current", cp_hi_sel, 1);
    two_wire = 0; cp_hi = 0; repeat (2) @(negedge clk);
    check("R9 three-wire forces high", cp_hi_sel, 1);
    two_wire = 1;
  endtask

  initial begin
    t_reset();
    t_lock_two_wire();
    t_detune();
    t_ref_sel();
    t_three_wire();
    t_pump_off();
    t_loop_off();
    t_test_bit();
    t_cur_sel();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    wait (cyc >= 190000);
    if (!done) begin
      done = 1;
      errors++; checks++;
      $display("FAIL watchdog: actual=%0d expected=%0d", cyc, 190000);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule